// File: doc/BRIEF.md
# Magic-word connect handshake controller

This block sits on the device side of a host register port and runs the connect handshake that brings the device's ring buffers and DMA engine up. The host first arms the block by writing a fixed magic word to a notification register. It then writes the value one to a connect doorbell. After a fixed response latency, the block raises a connect flag in its status register, which the host polls, and sends a one-cycle initialise pulse to the ring and DMA logic.

Once the connection is up, the host writes configuration words, such as a bank shift or a readback count, to a configuration register. The block presents each accepted word on a held output, together with a one-cycle strobe. Configuration writes that arrive before the connection is up are dropped. Doorbells that arrive without the exact magic word, or that carry any value other than one, are ignored.

Top module: `conn_hs_top`

## Requirements
- R1: After reset, the status register reads 0x00000000, the configuration register and `cfg_word` are 0, and `init_pulse` and `cfg_valid` are low.
- R2: A write to the magic register at offset 0xC02C stores the full 32-bit word, and a read of that offset returns the last stored word.
- R3: A doorbell write of 0x00000001 to offset 0x2260 is accepted while the magic register holds exactly 0x0ACEFACE. Status bit 21 at offset 0xC030 becomes set exactly `CONNECT_LAT` clock edges after the edge that accepts the doorbell.
- R4: A doorbell write while the magic register holds anything other than 0x0ACEFACE is ignored, and bit 21 stays clear.
- R5: A doorbell write of any value other than 0x00000001 is ignored, even when the block is armed.
- R6: `init_pulse` is high for exactly one cycle, in the first cycle in which bit 21 is set, and never at any other time.
- R7: Once set, bit 21 stays set until reset. Later doorbells produce no further `init_pulse`.
- R8: A write to the configuration register at offset 0xC000 while bit 21 is clear is dropped: `cfg_word`, `cfg_valid` and the readback are unchanged.
- R9: A configuration write while bit 21 is set updates `cfg_word` and the readback after the accepting edge, and raises `cfg_valid` for exactly that one cycle.
- R10: Reads have a one-cycle latency: `host_rdata` is updated at the edge that samples `host_rd` and holds otherwise. Unmapped offsets, the doorbell offset and all status bits other than 21 read as 0.
- R11: A second accepted-looking doorbell while a connection is pending does not restart the latency count.
- R12: Overwriting the magic register with another value disarms the block, so a following doorbell is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W (16) | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| init_pulse | output | 1 | One-cycle pulse that starts ring and DMA initialisation |
| cfg_word | output | 32 | Last accepted configuration word |
| cfg_valid | output | 1 | One-cycle strobe for an accepted configuration word |

## Verification
Read data is due one edge after the read strobe is sampled. The bench therefore drives each read at a falling edge and compares `host_rdata` at the next falling edge. The connect flag and `init_pulse` are due exactly `CONNECT_LAT` edges after the doorbell edge, so the bench counts edges from that write and checks `init_pulse` at every falling edge in the window, expecting a high level only at the last one. `cfg_word` and `cfg_valid` are due one edge after the configuration write and are checked at the falling edge that follows it, with `cfg_valid` checked low again one cycle later.

// File: rtl/conn_hs_pkg.sv
package conn_hs_pkg;

  localparam logic [31:0] MAGIC_WORD   = 32'h0ACE_FACE;
  localparam logic [31:0] DOOR_VALUE   = 32'h0000_0001;
  localparam int          STAT_UP_BIT  = 21;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_MAGIC = 3'd1,
    SEL_DOOR  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_CFG   = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/conn_hs_decode.sv
module conn_hs_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] OFF_MAGIC = 16'hC02C,
  parameter logic [15:0] OFF_DOOR  = 16'h2260,
  parameter logic [15:0] OFF_STAT  = 16'hC030,
  parameter logic [15:0] OFF_CFG   = 16'hC000
) (
  input  logic [ADDR_W-1:0]    addr,
  output conn_hs_pkg::reg_sel_e sel
);
  import conn_hs_pkg::*;

  always_comb begin
    if (addr == ADDR_W'(OFF_MAGIC))      sel = SEL_MAGIC;
    else if (addr == ADDR_W'(OFF_DOOR))  sel = SEL_DOOR;
    else if (addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CFG))   sel = SEL_CFG;
    else                                 sel = SEL_NONE;
  end
endmodule

// File: rtl/conn_hs_arm.sv
module conn_hs_arm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_magic,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] magic_q,
  output logic              armed
);
  import conn_hs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)           magic_q <= '0;
    else if (wr_magic) magic_q <= wdata;
  end

  assign armed = (magic_q == DATA_W'(MAGIC_WORD));
endmodule

// File: rtl/conn_hs_timer.sv
module conn_hs_timer #(
  parameter int CONNECT_LAT = 8,
  localparam int CNT_W = (CONNECT_LAT < 2) ? 1 : $clog2(CONNECT_LAT)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic link_up,
  output logic init_pulse
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      busy       <= 1'b0;
      link_up    <= 1'b0;
      init_pulse <= 1'b0;
    end else begin
      init_pulse <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          link_up    <= 1'b1;
          init_pulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start && !link_up) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(CONNECT_LAT - 1);
      end
    end
  end

  // R7: connection flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    link_up |=> link_up);
  // R6: initialise is a single-cycle pulse
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> !init_pulse);
  // R6: pulse coincides with the first cycle of the connection flag
  a_r6_first_up: assert property (@(posedge clk) disable iff (rst)
    init_pulse |-> (link_up && !$past(link_up)));
  // R11: a pending connect runs to completion
  a_r11_pending: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || link_up));
endmodule

// File: rtl/conn_hs_cfg.sv
module conn_hs_cfg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              link_up,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_word,
  output logic              cfg_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word  <= '0;
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= 1'b0;
      if (wr_cfg && link_up) begin
        cfg_word  <= wdata;
        cfg_valid <= 1'b1;
      end
    end
  end

  // R8: word only changes after an accepted write
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> $stable(cfg_word) || $past(rst));
  // R9: accepted words only once connected
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> link_up);
endmodule

// File: rtl/conn_hs_top.sv
module conn_hs_top #(
  parameter int ADDR_W      = 16,
  parameter int CONNECT_LAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              init_pulse,
  output logic [31:0]       cfg_word,
  output logic              cfg_valid
);
  import conn_hs_pkg::*;

  localparam int DATA_W = 32;

  reg_sel_e          sel;
  logic [DATA_W-1:0] magic_q;
  logic              armed;
  logic              busy;
  logic              link_up;
  logic              door_ok;

  conn_hs_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (host_addr),
    .sel  (sel)
  );

  conn_hs_arm #(.DATA_W(DATA_W)) u_arm (
    .clk      (clk),
    .rst      (rst),
    .wr_magic (host_wr && sel == SEL_MAGIC),
    .wdata    (host_wdata),
    .magic_q  (magic_q),
    .armed    (armed)
  );

  assign door_ok = host_wr && (sel == SEL_DOOR) &&
                   (host_wdata == DOOR_VALUE) && armed;

  conn_hs_timer #(.CONNECT_LAT(CONNECT_LAT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (door_ok),
    .busy       (busy),
    .link_up    (link_up),
    .init_pulse (init_pulse)
  );

  conn_hs_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_cfg    (host_wr && sel == SEL_CFG),
    .link_up   (link_up),
    .wdata     (host_wdata),
    .cfg_word  (cfg_word),
    .cfg_valid (cfg_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      unique case (sel)
        SEL_MAGIC: host_rdata <= magic_q;
        SEL_STAT:  host_rdata <= DATA_W'(link_up) << STAT_UP_BIT;
        SEL_CFG:   host_rdata <= cfg_word;
        default:   host_rdata <= '0;
      endcase
    end
  end

  // R10: read data holds when no read is sampled
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(host_rd) && !$past(rst)) |-> $stable(host_rdata));
  // R3: the connection flag only rises at the end of a pending connect
  a_r3_from_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(busy));
  // R4: a pending connect only begins on an armed block
  a_r4_armed_start: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !$past(rst)) |-> $past(armed));
endmodule

// File: tb/conn_hs_top_bench.sv
module conn_hs_top_bench;
  localparam int LAT = 4;
  localparam logic [15:0] A_MAG  = 16'hC02C;
  localparam logic [15:0] A_DOOR = 16'h2260;
  localparam logic [15:0] A_STAT = 16'hC030;
  localparam logic [15:0] A_CFG  = 16'hC000;
  localparam logic [31:0] UP     = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        init_pulse;
  logic [31:0] cfg_word;
  logic        cfg_valid;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  conn_hs_top #(.ADDR_W(16), .CONNECT_LAT(LAT)) u_conn_hs_top (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .init_pulse (init_pulse),
    .cfg_word   (cfg_word),
    .cfg_valid  (cfg_valid)
  );

  // vector: req(8) op(2: 1 write, 2 read-check) addr(16) wdata(32) expect(32)
  localparam int NV = 30;
  localparam logic [89:0] VEC [NV] = '{
    {8'd1,  2'd2, A_STAT, 32'h0, 32'h0},          // R1
    {8'd1,  2'd2, A_CFG,  32'h0, 32'h0},          // R1
    {8'd8,  2'd1, A_CFG,  32'h55, 32'h0},         // R8 early cfg
    {8'd8,  2'd2, A_CFG,  32'h0, 32'h0},          // R8
    {8'd4,  2'd1, A_DOOR, 32'h1, 32'h0},          // R4 no magic
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd2,  2'd1, A_MAG,  32'h0ACEFACF, 32'h0},   // R2 / R4 wrong magic
    {8'd2,  2'd2, A_MAG,  32'h0, 32'h0ACEFACF},
    {8'd4,  2'd1, A_DOOR, 32'h1, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd4,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd5,  2'd1, A_MAG,  32'h0ACEFACE, 32'h0},   // R5 armed, bad value
    {8'd5,  2'd1, A_DOOR, 32'h2, 32'h0},
    {8'd5,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd5,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd5,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd5,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd5,  2'd2, A_STAT, 32'h0, 32'h0},
    {8'd12, 2'd1, A_MAG,  32'h12345678, 32'h0},   // R12 disarm
    {8'd12, 2'd1, A_DOOR, 32'h1, 32'h0},
    {8'd12, 2'd2, A_STAT, 32'h0, 32'h0},
    {8'd12, 2'd2, A_STAT, 32'h0, 32'h0},
    {8'd10, 2'd2, 16'h1234, 32'h0, 32'h0}         // R10 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, host_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 init_pulse", 32'(init_pulse), 32'h0);
    chk("R1 cfg_valid", 32'(cfg_valid), 32'h0);
    chk("R1 cfg_word", cfg_word, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][89:82], i);
      if (VEC[i][81:80] == 2'd1) do_wr(VEC[i][79:64], VEC[i][63:32]);
      else do_rd(tag, VEC[i][79:64], VEC[i][31:0]);
      chk({tag, " init"}, 32'(init_pulse), 32'h0);
    end

    // R3 R6 R11: timed connect with a repeated doorbell while pending
    do_wr(A_MAG, 32'h0ACEFACE);
    do_wr(A_DOOR, 32'h1);
    chk("R6 n0", 32'(init_pulse), 32'h0);
    for (int n = 1; n <= LAT + 1; n++) begin
      if (n == 2) begin
        host_wr = 1'b1; host_addr = A_DOOR; host_wdata = 32'h1;
      end
      @(negedge clk);
      host_wr = 1'b0;
      chk($sformatf("R3 R11 pulse n%0d", n), 32'(init_pulse), (n == LAT) ? 32'h1 : 32'h0);
    end
    do_rd("R3 status up", A_STAT, UP);

    // R7: sticky, no further pulse
    do_wr(A_DOOR, 32'h1);
    for (int n = 0; n < LAT + 2; n++) begin
      @(negedge clk);
      chk("R7 no pulse", 32'(init_pulse), 32'h0);
    end
    do_rd("R7 still up", A_STAT, UP);
    do_rd("R2 magic", A_MAG, 32'h0ACEFACE);
    do_rd("R10 door reads 0", A_DOOR, 32'h0);

    // R9: configuration after connect
    do_wr(A_CFG, 32'h0000_0003);
    chk("R9 word", cfg_word, 32'h3);
    chk("R9 valid", 32'(cfg_valid), 32'h1);
    @(negedge clk);
    chk("R9 valid drop", 32'(cfg_valid), 32'h0);
    do_wr(A_CFG, 32'h0000_0010);
    chk("R9 word2", cfg_word, 32'h10);
    do_rd("R9 readback", A_CFG, 32'h10);
    chk("R10 hold", host_rdata, 32'h10);
    @(negedge clk);
    chk("R10 hold2", host_rdata, 32'h10);

    // R1 R7: reset clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_rd("R1 status after reset", A_STAT, 32'h0);
    do_rd("R1 cfg after reset", A_CFG, 32'h0);
    chk("R1 cfg_word after reset", cfg_word, 32'h0);

    // R3 with a minimal gap
    do_wr(A_MAG, 32'h0ACEFACE);
    do_wr(A_DOOR, 32'h1);
    repeat (LAT - 1) @(negedge clk);
    chk("R3 not yet", 32'(init_pulse), 32'h0);
    @(negedge clk);
    chk("R3 pulse again", 32'(init_pulse), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule